// File: doc/BRIEF.md
# Dual-Bridge Pole-Voltage Modulator

This block turns three signed voltage demands into gate drive for two single-phase rectifier bridges connected in parallel on one grid and one dc link. The demands are the differential voltage for bridge A, the differential voltage for bridge B, and the common-mode demand of the loop that suppresses current circulating between the bridges. Four pole voltages can realise three demands, so one degree of freedom is left. The block fills it with an offset voltage. The offset is placed between a lower and an upper bound set by the dc-link headroom, and a distribution weight `mu` picks the point between the bounds.

Each of the four pole references is sampled at the turning points of a triangular carrier. It is then compared with the carrier to give a switching demand. A dead-time state machine per leg turns that demand into complementary upper and lower gate signals. The carrier mode is selectable. In single mode every leg uses the same triangle. In interleaved mode the bridge B legs use a triangle shifted by half a period, which is the negated triangle.

The carrier is an up/down counter stepping in the same units as the voltages. Its amplitude is half the dc-link reference, and one step happens every `tick_div+1` clocks. Its named states are CAR_UP (rising) and CAR_DOWN (falling). The transition CAR_UP→CAR_DOWN is the peak and CAR_DOWN→CAR_UP is the valley. Each leg has four named states:
- LEG_LO: lower gate closed.
- LEG_RISE: both gates open, on the way up.
- LEG_HI: upper gate closed.
- LEG_FALL: both gates open, on the way down.

The leg transitions are:
- LO→RISE (or LO→HI with zero dead time) when the demand rises.
- RISE→HI when the dead time expires.
- RISE→LO when the demand drops early.
- HI→FALL (or HI→LO) when the demand falls.
- FALL→LO when the dead time expires.
- FALL→HI when the demand returns early.

Top module: `pr_pwm_mod`

## Requirements
- R1: While reset is held, every gate output is 0 (open) and all four pole references read 0. After release, each leg begins in LEG_FALL.
- R2: With H = the carrier amplitude, the raw references are rA1 = va, rA2 = 0, rB1 = floor((va+vb-vc_circ)/2) and rB2 = floor((va-vb-vc_circ)/2). The offset is vx = floor((m·(H - max r) + (256-m)·(-H - min r))/256). Each pole equals its raw reference plus vx. Pole field i sits at pole_ref[16i+15:16i], in the order A1, A2, B1, B2.
- R3: `mu` is unsigned with 8 fraction bits, and values above 256 act as 256. With m = 0 the smallest pole equals -H. With m = 256 the largest pole equals +H.
- R4: H = floor(vdc_ref/2), or 0 when vdc_ref is negative. Every pole is saturated to the range [-H, +H].
- R5: The pole references change only on the clock edge where the carrier turns at a peak or a valley. An input change between turns leaves pole_ref unchanged until the next turn.
- R6: The carrier steps by one every tick_div+1 clocks between -H and +H, so one full period lasts 4H(tick_div+1) clocks. The demand of a leg is pole > carrier. With zero dead time, the upper gate is closed for (2(p+H)-1)(tick_div+1) clocks per period when p > -H, and for 0 clocks when p = -H.
- R7: With dual_carrier = 0, all four legs compare against the same carrier, so legs with equal poles switch identically.
- R8: With dual_carrier = 1, legs A1 and A2 use the carrier and legs B1 and B2 use its negation (half-period shift). With all poles at 0, the upper gates of A1 and B1 are never closed together.
- R9: Bit i of gate_hi and gate_lo drives leg i (0 = A1, 1 = A2, 2 = B1, 3 = B2). A 1 means the switch is closed. The upper and lower gates of one leg are never 1 together.
- R10: On every commutation both gates of the leg stay open for dead_cyc clocks. Per carrier period, the upper gate then loses dead_cyc clocks, the lower gate loses dead_cyc clocks, and the leg is fully open for 2·dead_cyc clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| va_ref | input | 16 | Bridge A differential voltage demand, signed |
| vb_ref | input | 16 | Bridge B differential voltage demand, signed |
| circ_ref | input | 16 | Circulating-loop common-mode demand, signed |
| vdc_ref | input | 16 | Dc-link voltage reference, signed |
| mu | input | 9 | Offset distribution weight, unsigned, 8 fraction bits |
| dual_carrier | input | 1 | 1 selects interleaved carriers for bridge B |
| tick_div | input | 8 | Carrier step divider (step every tick_div+1 clocks) |
| dead_cyc | input | 8 | Dead time in clocks |
| gate_hi | output | 4 | Upper switch gates, one per leg |
| gate_lo | output | 4 | Lower switch gates, one per leg |
| pole_ref | output | 64 | Sampled pole references, four signed 16-bit fields |

## Verification
A new set of demands reaches pole_ref on the clock edge of the next carrier turn. That turn comes at most 2H(tick_div+1) clocks after the change, or 4H(tick_div+1) clocks when the dc-link reference itself changes, because the amplitude is only taken at a valley. The bench waits past that bound before it compares the poles. The gate outputs follow the compare one clock after a pole or carrier update, plus the dead time. For that reason gate checks count closed clocks over one whole carrier period, and only after two settling periods, so the phase of the window does not matter. The hold check starts just after a pole change is seen. It then watches for less than half of the gap to the next turn.

// File: rtl/pr_pwm_pkg.sv
package pr_pwm_pkg;

    localparam int NLEG = 4;

    typedef enum logic [1:0] {
        LEG_LO,
        LEG_RISE,
        LEG_HI,
        LEG_FALL
    } leg_state_e;

    typedef enum logic {
        CAR_UP,
        CAR_DOWN
    } car_state_e;

endpackage

// File: rtl/pr_carrier.sv
module pr_carrier
    import pr_pwm_pkg::*;
#(
    parameter int W    = 16,
    parameter int DIVW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIVW-1:0]     tick_div,
    input  logic signed [W-1:0] h_in,
    output logic signed [W-1:0] car,
    output logic signed [W-1:0] hlim,
    output logic                samp,
    output logic                at_valley
);

    car_state_e          cst, cst_n;
    logic [DIVW-1:0]     pre, pre_n;
    logic signed [W-1:0] car_n, hlim_n;
    logic                tick, at_peak;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cst  <= CAR_DOWN;
            pre  <= '0;
            car  <= '0;
            hlim <= '0;
        end else begin
            cst  <= cst_n;
            pre  <= pre_n;
            car  <= car_n;
            hlim <= hlim_n;
        end
    end

    // next state and turn events
    always_comb begin
        tick      = (pre == tick_div);
        pre_n     = tick ? '0 : pre + 1'b1;
        cst_n     = cst;
        car_n     = car;
        hlim_n    = hlim;
        at_peak   = 1'b0;
        at_valley = 1'b0;
        if (tick) begin
            unique case (cst)
                CAR_UP: begin
                    if (car >= hlim) begin
                        at_peak = 1'b1;
                        cst_n   = CAR_DOWN;
                        car_n   = car - 1'b1;
                    end else begin
                        car_n = car + 1'b1;
                    end
                end
                CAR_DOWN: begin
                    if (car <= -hlim) begin
                        at_valley = 1'b1;
                        cst_n     = CAR_UP;
                        hlim_n    = h_in;
                        car_n     = car + 1'b1;
                    end else begin
                        car_n = car - 1'b1;
                    end
                end
                default: cst_n = CAR_DOWN;
            endcase
        end
    end

    assign samp = at_peak | at_valley;

endmodule

// File: rtl/pr_pole_calc.sv
module pr_pole_calc
    import pr_pwm_pkg::*;
#(
    parameter int W       = 16,
    parameter int MU_FRAC = 8
) (
    input  logic signed [W-1:0]  va,
    input  logic signed [W-1:0]  vb,
    input  logic signed [W-1:0]  vcirc,
    input  logic signed [W-1:0]  h,
    input  logic [MU_FRAC:0]     mu,
    output logic [NLEG*W-1:0]    pole
);

    localparam int EW     = W + 4;
    localparam int MUW    = MU_FRAC + 1;
    localparam int PW     = EW + MUW + 2;
    localparam int MU_ONE = 1 << MU_FRAC;

    logic signed [EW-1:0] raw [NLEG];
    logic signed [EW-1:0] hi01, hi23, lo01, lo23, vmax, vmin;
    logic signed [EW-1:0] xmax, xmin, vx, h_e;
    logic signed [PW-1:0] w_hi, w_lo, acc;
    logic [MUW-1:0]       mu_c;

    always_comb begin
        h_e    = EW'(h);
        raw[0] = EW'(va);
        raw[1] = '0;
        raw[2] = (EW'(va) + EW'(vb) - EW'(vcirc)) >>> 1;
        raw[3] = (EW'(va) - EW'(vb) - EW'(vcirc)) >>> 1;
    end

    // max/min tree over the raw references
    always_comb begin
        hi01 = (raw[0] > raw[1]) ? raw[0] : raw[1];
        hi23 = (raw[2] > raw[3]) ? raw[2] : raw[3];
        lo01 = (raw[0] < raw[1]) ? raw[0] : raw[1];
        lo23 = (raw[2] < raw[3]) ? raw[2] : raw[3];
        vmax = (hi01 > hi23) ? hi01 : hi23;
        vmin = (lo01 < lo23) ? lo01 : lo23;
    end

    // offset bounds and weighted offset
    always_comb begin
        xmax = h_e - vmax;
        xmin = -h_e - vmin;
        mu_c = (mu > MUW'(MU_ONE)) ? MUW'(MU_ONE) : mu;
        w_hi = PW'({1'b0, mu_c});
        w_lo = PW'(MU_ONE) - w_hi;
        acc  = PW'(xmax) * w_hi + PW'(xmin) * w_lo;
        vx   = EW'(acc >>> MU_FRAC);
    end

    for (genvar i = 0; i < NLEG; i++) begin : g_sat
        logic signed [EW-1:0] t;
        always_comb begin
            t = raw[i] + vx;
            if (t > h_e)
                pole[i*W +: W] = W'(h_e);
            else if (t < -h_e)
                pole[i*W +: W] = W'(-h_e);
            else
                pole[i*W +: W] = W'(t);
        end
    end

endmodule

// File: rtl/pr_leg_dt.sv
module pr_leg_dt
    import pr_pwm_pkg::*;
#(
    parameter int DTW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           demand,
    input  logic [DTW-1:0] dead_cyc,
    output logic           g_hi,
    output logic           g_lo
);

    leg_state_e     st, st_n;
    logic [DTW-1:0] cnt, cnt_n;
    logic           dt_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= LEG_FALL;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // next state
    always_comb begin
        st_n    = st;
        cnt_n   = cnt;
        dt_done = ({1'b0, cnt} + {{DTW{1'b0}}, 1'b1}) >= {1'b0, dead_cyc};
        unique case (st)
            LEG_LO: begin
                if (demand) begin
                    if (dead_cyc == '0) begin
                        st_n = LEG_HI;
                    end else begin
                        st_n  = LEG_RISE;
                        cnt_n = '0;
                    end
                end
            end
            LEG_RISE: begin
                if (!demand)
                    st_n = LEG_LO;
                else if (dt_done)
                    st_n = LEG_HI;
                else
                    cnt_n = cnt + 1'b1;
            end
            LEG_HI: begin
                if (!demand) begin
                    if (dead_cyc == '0) begin
                        st_n = LEG_LO;
                    end else begin
                        st_n  = LEG_FALL;
                        cnt_n = '0;
                    end
                end
            end
            LEG_FALL: begin
                if (demand)
                    st_n = LEG_HI;
                else if (dt_done)
                    st_n = LEG_LO;
                else
                    cnt_n = cnt + 1'b1;
            end
            default: st_n = LEG_FALL;
        endcase
    end

    // outputs
    always_comb begin
        g_hi = (st == LEG_HI);
        g_lo = (st == LEG_LO);
    end

endmodule

// File: rtl/pr_pwm_mod.sv
module pr_pwm_mod
    import pr_pwm_pkg::*;
#(
    parameter int W       = 16,
    parameter int MU_FRAC = 8,
    parameter int DIVW    = 8,
    parameter int DTW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [W-1:0]  va_ref,
    input  logic signed [W-1:0]  vb_ref,
    input  logic signed [W-1:0]  circ_ref,
    input  logic signed [W-1:0]  vdc_ref,
    input  logic [MU_FRAC:0]     mu,
    input  logic                 dual_carrier,
    input  logic [DIVW-1:0]      tick_div,
    input  logic [DTW-1:0]       dead_cyc,
    output logic [NLEG-1:0]      gate_hi,
    output logic [NLEG-1:0]      gate_lo,
    output logic [NLEG*W-1:0]    pole_ref
);

    localparam int HALF = NLEG / 2;

    logic signed [W-1:0] h_in, h_sel, hlim, car, car_inv;
    logic                samp, at_valley;
    logic [NLEG*W-1:0]   pole_nx;

    assign h_in    = vdc_ref[W-1] ? '0 : (vdc_ref >>> 1);
    assign h_sel   = at_valley ? h_in : hlim;
    assign car_inv = -car;

    pr_carrier #(.W(W), .DIVW(DIVW)) u_car (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_div  (tick_div),
        .h_in      (h_in),
        .car       (car),
        .hlim      (hlim),
        .samp      (samp),
        .at_valley (at_valley)
    );

    pr_pole_calc #(.W(W), .MU_FRAC(MU_FRAC)) u_calc (
        .va    (va_ref),
        .vb    (vb_ref),
        .vcirc (circ_ref),
        .h     (h_sel),
        .mu    (mu),
        .pole  (pole_nx)
    );

    // references move only at carrier turning points
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pole_ref <= '0;
        else if (samp)
            pole_ref <= pole_nx;
    end

    for (genvar i = 0; i < NLEG; i++) begin : g_leg
        logic signed [W-1:0] ref_i, car_sel;
        logic                demand;
        assign ref_i = pole_ref[i*W +: W];
        if (i < HALF) begin : g_a
            assign car_sel = car;
        end else begin : g_b
            assign car_sel = dual_carrier ? car_inv : car;
        end
        assign demand = (ref_i > car_sel);

        pr_leg_dt #(.DTW(DTW)) u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .demand   (demand),
            .dead_cyc (dead_cyc),
            .g_hi     (gate_hi[i]),
            .g_lo     (gate_lo[i])
        );
    end

endmodule

// File: rtl/pr_pwm_chk.sv
module pr_pwm_chk
    import pr_pwm_pkg::*;
#(
    parameter int W   = 16,
    parameter int DTW = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NLEG-1:0]     gate_hi,
    input logic [NLEG-1:0]     gate_lo,
    input logic [DTW-1:0]      dead_cyc,
    input logic                samp,
    input logic signed [W-1:0] hlim,
    input logic [NLEG*W-1:0]   pole_ref
);

    // R9
    gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == '0);

    // R10
    dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dead_cyc) != '0) |->
        (((gate_hi & ~$past(gate_hi) & $past(gate_lo)) == '0) &&
         ((gate_lo & ~$past(gate_lo) & $past(gate_hi)) == '0)));

    // R5
    pole_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !samp |=> $stable(pole_ref));

    for (genvar i = 0; i < NLEG; i++) begin : g_rng
        // R4
        pole_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($signed(pole_ref[i*W +: W]) <= hlim) &&
            ($signed(pole_ref[i*W +: W]) >= -hlim));
    end

endmodule

bind pr_pwm_mod pr_pwm_chk #(.W(W), .DTW(DTW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate_hi  (gate_hi),
    .gate_lo  (gate_lo),
    .dead_cyc (dead_cyc),
    .samp     (samp),
    .hlim     (hlim),
    .pole_ref (pole_ref)
);

// File: tb/tb_pr_pwm_mod.sv
module tb_pr_pwm_mod;

    localparam int W = 16;
    localparam int H = 100;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                rst_n;
    logic signed [W-1:0] va, vb, vo, vc;
    logic [8:0]          mu;
    logic                dual;
    logic [7:0]          tdiv, dead;
    logic [3:0]          ghi, glo;
    logic [4*W-1:0]      pref;

    int errors = 0;
    int checks = 0;
    int c_hi[4], c_lo[4], c_off[4];
    int c_hl, c_ov02, c_or02;

    pr_pwm_mod dut (
        .clk(clk), .rst_n(rst_n), .va_ref(va), .vb_ref(vb), .circ_ref(vo),
        .vdc_ref(vc), .mu(mu), .dual_carrier(dual), .tick_div(tdiv),
        .dead_cyc(dead), .gate_hi(ghi), .gate_lo(glo), .pole_ref(pref)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pole_at(input int i);
        return int'($signed(pref[i*W +: W]));
    endfunction

    function automatic void exp_poles(input int a, input int b, input int o,
                                      input int dc, input int m, output int p[4]);
        int h, vmax, vmin, vx, t, mm;
        int r[4];
        h = (dc < 0) ? 0 : (dc >>> 1);
        r[0] = a; r[1] = 0;
        r[2] = (a + b - o) >>> 1;
        r[3] = (a - b - o) >>> 1;
        vmax = r[0]; vmin = r[0];
        for (int i = 1; i < 4; i++) begin
            if (r[i] > vmax) vmax = r[i];
            if (r[i] < vmin) vmin = r[i];
        end
        mm = (m > 256) ? 256 : m;
        vx = (mm * (h - vmax) + (256 - mm) * (-h - vmin)) >>> 8;
        for (int i = 0; i < 4; i++) begin
            t = r[i] + vx;
            if (t > h) t = h;
            if (t < -h) t = -h;
            p[i] = t;
        end
    endfunction

    function automatic int raw_on(input int p, input int h);
        return (p <= -h) ? 0 : 2 * (p + h) - 1;
    endfunction

    task automatic set_in(input int a, input int b, input int o, input int m);
        @(negedge clk);
        va = W'(a); vb = W'(b); vo = W'(o); mu = 9'(m);
    endtask

    task automatic check_poles(input string req);
        int p[4];
        exp_poles(int'(va), int'(vb), int'(vo), int'(vc), int'(mu), p);
        for (int i = 0; i < 4; i++) chk(req, pole_at(i), p[i]);
    endtask

    task automatic count_window(input int n);
        for (int i = 0; i < 4; i++) begin c_hi[i] = 0; c_lo[i] = 0; c_off[i] = 0; end
        c_hl = 0; c_ov02 = 0; c_or02 = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                c_hi[i]  += int'(ghi[i]);
                c_lo[i]  += int'(glo[i]);
                c_off[i] += int'(!ghi[i] && !glo[i]);
                c_hl     += int'(ghi[i] && glo[i]);
            end
            c_ov02 += int'(ghi[0] && ghi[2]);
            c_or02 += int'(ghi[0] || ghi[2]);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R6: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int p[4], q[4];
        int found, stable, mn, mx;
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        va = '0; vb = '0; vo = '0; vc = W'(2 * H); mu = 9'd128;
        dual = 1'b0; tdiv = '0; dead = '0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 gates open", int'(ghi | glo), 0);
        chk("R1 poles zero", int'(pref == '0), 1);
        rst_n = 1'b1;

        // R2 directed
        set_in(100, 0, 0, 128);
        repeat (2 * H + 5) @(negedge clk);
        check_poles("R2 directed");

        // R2 random
        for (int n = 0; n < 16; n++) begin
            set_in(int'($urandom_range(240)) - 120, int'($urandom_range(240)) - 120,
                   int'($urandom_range(240)) - 120, int'($urandom_range(300)));
            repeat (2 * H + 5) @(negedge clk);
            check_poles("R2 random");
        end

        // R3 mu extremes
        set_in(60, -30, 20, 0);
        repeat (2 * H + 5) @(negedge clk);
        mn = pole_at(0);
        for (int i = 1; i < 4; i++) if (pole_at(i) < mn) mn = pole_at(i);
        chk("R3 mu=0 min pole", mn, -H);
        set_in(60, -30, 20, 256);
        repeat (2 * H + 5) @(negedge clk);
        mx = pole_at(0);
        for (int i = 1; i < 4; i++) if (pole_at(i) > mx) mx = pole_at(i);
        chk("R3 mu=1 max pole", mx, H);
        exp_poles(60, -30, 20, 2 * H, 256, q);
        set_in(60, -30, 20, 400);
        repeat (2 * H + 5) @(negedge clk);
        for (int i = 0; i < 4; i++) chk("R3 mu clamp", pole_at(i), q[i]);

        // R4 saturation
        set_in(300, -300, 100, 128);
        repeat (2 * H + 5) @(negedge clk);
        check_poles("R4 saturate");
        @(negedge clk); vc = W'(-50);
        repeat (8 * H + 10) @(negedge clk);
        for (int i = 0; i < 4; i++) chk("R4 negative dc link", pole_at(i), 0);
        @(negedge clk); vc = W'(2 * H);
        repeat (8 * H + 10) @(negedge clk);

        // R5 sampling at turns only
        set_in(-40, 20, 0, 128);
        repeat (2 * H + 5) @(negedge clk);
        exp_poles(40, 10, -6, 2 * H, 128, p);
        set_in(40, 10, -6, 128);
        found = 0;
        for (int k = 0; k < 6 * H && found == 0; k++) begin
            @(negedge clk);
            if (pole_at(0) == p[0] && pole_at(1) == p[1] &&
                pole_at(2) == p[2] && pole_at(3) == p[3]) found = 1;
        end
        chk("R5 update seen", found, 1);
        va = W'(-40); vb = W'(20); vo = W'(0);
        stable = 1;
        for (int k = 0; k < H - 10; k++) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) if (pole_at(i) != p[i]) stable = 0;
        end
        chk("R5 hold between turns", stable, 1);
        repeat (2 * H + 10) @(negedge clk);
        check_poles("R5 next turn");

        // R6 duty per leg, single carrier, no dead time
        set_in(100, 0, 0, 128);
        repeat (8 * H) @(negedge clk);
        exp_poles(100, 0, 0, 2 * H, 128, p);
        count_window(4 * H);
        for (int i = 0; i < 4; i++) chk("R6 upper closed count", c_hi[i], raw_on(p[i], H));

        // R7 single carrier, equal poles switch together
        set_in(0, 0, 0, 128);
        repeat (8 * H) @(negedge clk);
        count_window(4 * H);
        chk("R7 shared carrier overlap", c_ov02, 2 * H - 1);

        // R8 interleaved carriers
        @(negedge clk); dual = 1'b1;
        repeat (8 * H) @(negedge clk);
        count_window(4 * H);
        chk("R8 no overlap", c_ov02, 0);
        chk("R8 B leg count", c_hi[2], 2 * H - 1);
        chk("R8 union", c_or02, 4 * H - 2);
        @(negedge clk); dual = 1'b0;

        // R6 divider stretches period
        @(negedge clk); tdiv = 8'd1;
        repeat (16 * H) @(negedge clk);
        count_window(8 * H);
        chk("R6 divided period", c_hi[0], 2 * (2 * H - 1));
        @(negedge clk); tdiv = '0;

        // R10 / R9 dead time
        set_in(100, 0, 0, 128);
        @(negedge clk); dead = 8'd5;
        repeat (8 * H) @(negedge clk);
        count_window(4 * H);
        chk("R10 upper minus dead", c_hi[0], raw_on(50, H) - 5);
        chk("R10 lower minus dead", c_lo[0], 4 * H - raw_on(50, H) - 5);
        chk("R10 both open", c_off[0], 10);
        chk("R9 never both closed", c_hl, 0);

        finish_run();
    end

endmodule